// File: doc/BRIEF.md
# NAND Device Command Interface Controller

This block is the control logic that sits behind the multiplexed 8-bit bus of a NAND storage device. Bus cycles reach it already captured on the write strobe and tagged as command, address or data. It pairs setup and confirm commands and gathers the address bytes. It starts array operations through a request pulse and runs a busy timer for each one. It also keeps the status register and supplies the byte that each read strobe returns. That byte is status, an identification byte, or a byte of the page buffer taken at a column that advances by itself.

The array, the high-voltage circuits and the analog pin timing are outside the block. Array work appears as a one-cycle request that carries an operation code and a row. Page-load, program, erase and reset times are parameter cycle counts. The page buffer is a plain behavioural RAM with one byte for each column.

Top module: `nand_cmd_ctrl`

## Requirements
- R1: Command pairs start array work. 00h then 30h requests a page read (arr_op 0). 00h then 35h requests a copy-back read (arr_op 1). 80h then 10h, or 85h then 10h, requests a program (arr_op 2). 60h then D0h requests an erase (arr_op 3). Each request raises arr_start for one cycle. busy then stays high for exactly T_LOAD cycles (both reads), T_PROG cycles (program) or T_ERASE cycles (erase).
- R2: Bus cycles are tagged by cyc_kind: 1 is a command, 2 is an address, 0 is data. Read and program take four address bytes in this order: column low, column high (bits 3:0), row low, row high. Address bytes beyond the fourth are ignored. A column above 2111 is clamped to 2111. An erase takes two row bytes, and the request carries the row with its low PAGE_BITS bits forced to zero.
- R3: During program data input, each data byte is written into the buffer at the current column, and the column then advances. A further 85h followed by two column bytes moves the write column. Writes at column 2111 keep landing on 2111.
- R4: In page output mode, rd_byte shows the buffer byte at the current column. Each read strobe advances the column, which stops at 2111. 05h, two column bytes, then E0h moves the read column.
- R5: While busy, only 70h and FFh act. Any other command is ignored: it starts nothing, and it changes neither the sequence nor the output mode.
- R6: FFh, whether busy or ready, cancels the running operation and clears the pending sequence. busy then stays high for exactly T_RST cycles, and the fail bit is cleared. Afterwards 70h reads C0h when wp_n is high.
- R7: The status byte has bit 7 = wp_n (1 means not protected), bit 6 = 1 when ready and 0 when busy, bit 0 = 1 on a failure, and all other bits zero. After 70h every read returns status until 00h or 90h is written. 05h does not leave status mode.
- R8: 90h followed by address byte 00h makes the reads return C8h, D1h, 80h, 95h and 42h in turn, then 00h. Any other address byte makes every read return 00h.
- R9: After reset the block is in read address entry, so four address bytes and 30h start a page read with no 00h first. The same holds after FFh.
- R10: 80h, the address and 10h with no data byte in between start no program and leave busy low. A copy-back program (85h) needs no data.
- R11: If wp_n is low at 10h or D0h, no request is made, busy stays low and the fail bit is set. The next accepted program or erase clears the fail bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | A captured bus write cycle is present |
| cyc_kind | input | 2 | Cycle tag: 0 data, 1 command, 2 address |
| cyc_byte | input | 8 | Byte carried by the cycle |
| wp_n | input | 1 | Write-protect, low means protected |
| rd_strobe | input | 1 | One read strobe has completed |
| rd_byte | output | 8 | Byte the next read strobe returns |
| busy | output | 1 | Operation in progress |
| arr_start | output | 1 | One-cycle array request |
| arr_op | output | 2 | Request type: 0 read, 1 copy read, 2 program, 3 erase |
| arr_row | output | 16 | Row of the request |

## Verification
The hardest case to reach is a command that arrives while the busy timer is still running. It must be ignored, and the ports show nothing at that moment. The bench therefore starts a long erase, sends a setup command in the middle of it, and then completes the rest of that sequence after ready. A missing request then proves the setup was dropped. The abort case is handled the same way: FFh lands partway through a program, and the length of the remaining busy window is counted.

// File: rtl/nand_ctl_pkg.sv
package nand_ctl_pkg;

    typedef enum logic [1:0] {CY_DATA = 2'd0, CY_CMD = 2'd1, CY_ADDR = 2'd2} cyc_kind_e;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_CPRD = 2'd1, OP_PROG = 2'd2, OP_ERASE = 2'd3} arr_op_e;
    typedef enum logic [1:0] {OUT_PAGE, OUT_STAT, OUT_ID} out_sel_e;
    typedef enum logic [2:0] {S_IDLE, S_RD_ADDR, S_PROG, S_PCOL, S_ER_ADDR, S_OCOL, S_ID_ADDR} seq_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } row_t;

    localparam logic [7:0] K_RD_SETUP  = 8'h00;
    localparam logic [7:0] K_RD_GO     = 8'h30;
    localparam logic [7:0] K_CPRD_GO   = 8'h35;
    localparam logic [7:0] K_PG_SETUP  = 8'h80;
    localparam logic [7:0] K_COL_IN    = 8'h85;
    localparam logic [7:0] K_PG_GO     = 8'h10;
    localparam logic [7:0] K_ER_SETUP  = 8'h60;
    localparam logic [7:0] K_ER_GO     = 8'hD0;
    localparam logic [7:0] K_COL_OUT   = 8'h05;
    localparam logic [7:0] K_COL_DONE  = 8'hE0;
    localparam logic [7:0] K_STATUS    = 8'h70;
    localparam logic [7:0] K_IDENT     = 8'h90;
    localparam logic [7:0] K_RESET     = 8'hFF;

    function automatic logic [7:0] ident_byte(input logic ok, input logic [2:0] idx);
        logic [7:0] v;
        case (idx)
            3'd0:    v = 8'hC8;
            3'd1:    v = 8'hD1;
            3'd2:    v = 8'h80;
            3'd3:    v = 8'h95;
            3'd4:    v = 8'h42;
            default: v = 8'h00;
        endcase
        return ok ? v : 8'h00;
    endfunction

    function automatic logic [7:0] status_byte(input logic wp_n, input logic bsy, input logic fail);
        return {wp_n, ~bsy, 5'b0, fail};
    endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          busy
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
    parameter int COLS = 2112,
    parameter int AW   = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [COLS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nand_rd_mux.sv
module nand_rd_mux
    import nand_ctl_pkg::*;
(
    input  out_sel_e   sel,
    input  logic [7:0] stat,
    input  logic       id_ok,
    input  logic [2:0] id_idx,
    input  logic [7:0] page_byte,
    output logic [7:0] rd_byte
);
    always_comb begin
        case (sel)
            OUT_STAT: rd_byte = stat;
            OUT_ID:   rd_byte = ident_byte(id_ok, id_idx);
            default:  rd_byte = page_byte;
        endcase
    end
endmodule

// File: rtl/nand_cmd_ctrl.sv
module nand_cmd_ctrl
    import nand_ctl_pkg::*;
#(
    parameter int COLS      = 2112,
    parameter int PAGE_BITS = 6,
    parameter int T_LOAD    = 20,
    parameter int T_PROG    = 40,
    parameter int T_ERASE   = 60,
    parameter int T_RST     = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cyc_valid,
    input  logic [1:0]  cyc_kind,
    input  logic [7:0]  cyc_byte,
    input  logic        wp_n,
    input  logic        rd_strobe,
    output logic [7:0]  rd_byte,
    output logic        busy,
    output logic        arr_start,
    output logic [1:0]  arr_op,
    output logic [15:0] arr_row
);
    localparam int COL_W = $clog2(COLS);
    localparam int COL_HI = COL_W - 8;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
    localparam int TMAX_A = (T_LOAD > T_PROG) ? T_LOAD : T_PROG;
    localparam int TMAX_B = (T_ERASE > T_RST) ? T_ERASE : T_RST;
    localparam int TMAX = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [15:0] ROW_MASK = ~16'((1 << PAGE_BITS) - 1);

    seq_e             st;
    logic [2:0]       acnt;
    logic [COL_W-1:0] col;
    logic [7:0]       col_lo;
    row_t             row;
    out_sel_e         osel;
    logic             id_ok;
    logic [2:0]       id_idx;
    logic             fail;
    logic             data_seen;
    logic             cb;
    arr_op_e          op_q;

    logic cmd_ev, adr_ev, dat_ev, ok_cmd, do_rst;
    logic rd_go, pg_conf, er_conf, pg_go, er_go;
    logic tmr_load, buf_we;
    logic [TW-1:0] tmr_val;
    logic [COL_W-1:0] col_addr, col_inc;
    logic [7:0] page_byte;

    function automatic logic [COL_W-1:0] clamp_col(input logic [COL_W-1:0] c);
        return (c > LAST_COL) ? LAST_COL : c;
    endfunction

    always_comb begin
        cmd_ev   = cyc_valid && (cyc_kind == CY_CMD);
        adr_ev   = cyc_valid && (cyc_kind == CY_ADDR);
        dat_ev   = cyc_valid && (cyc_kind == CY_DATA);
        do_rst   = cmd_ev && (cyc_byte == K_RESET);
        ok_cmd   = cmd_ev && !busy;
        rd_go    = ok_cmd && ((cyc_byte == K_RD_GO) || (cyc_byte == K_CPRD_GO))
                   && (st == S_RD_ADDR) && (acnt == 3'd4);
        pg_conf  = ok_cmd && (cyc_byte == K_PG_GO) && (st == S_PROG) && (acnt == 3'd4)
                   && (cb || data_seen);
        er_conf  = ok_cmd && (cyc_byte == K_ER_GO) && (st == S_ER_ADDR) && (acnt == 3'd2);
        pg_go    = pg_conf && wp_n;
        er_go    = er_conf && wp_n;
        tmr_load = do_rst || rd_go || pg_go || er_go;
        if (do_rst)     tmr_val = TW'(T_RST);
        else if (rd_go) tmr_val = TW'(T_LOAD);
        else if (pg_go) tmr_val = TW'(T_PROG);
        else            tmr_val = TW'(T_ERASE);
        buf_we   = dat_ev && !busy && (st == S_PROG) && (acnt == 3'd4);
        col_addr = clamp_col({cyc_byte[COL_HI-1:0], col_lo});
        col_inc  = (col == LAST_COL) ? col : col + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_RD_ADDR; acnt <= '0; col <= '0; col_lo <= '0; row <= '0;
            osel <= OUT_PAGE; id_ok <= 1'b0; id_idx <= '0; fail <= 1'b0;
            data_seen <= 1'b0; cb <= 1'b0; op_q <= OP_READ; arr_row <= '0;
            arr_start <= 1'b0;
        end else begin
            arr_start <= 1'b0;
            if (do_rst) begin
                st <= S_RD_ADDR; acnt <= '0; col <= '0; osel <= OUT_PAGE;
                fail <= 1'b0; id_ok <= 1'b0; id_idx <= '0; data_seen <= 1'b0; cb <= 1'b0;
            end else if (cmd_ev && busy) begin
                if (cyc_byte == K_STATUS) osel <= OUT_STAT;
            end else if (ok_cmd) begin
                case (cyc_byte)
                    K_RD_SETUP: begin st <= S_RD_ADDR; acnt <= '0; osel <= OUT_PAGE; end
                    K_RD_GO, K_CPRD_GO: begin
                        st <= S_IDLE;
                        if (rd_go) begin
                            arr_start <= 1'b1;
                            op_q <= (cyc_byte == K_RD_GO) ? OP_READ : OP_CPRD;
                            arr_row <= row;
                        end
                    end
                    K_PG_SETUP: begin st <= S_PROG; acnt <= '0; cb <= 1'b0; data_seen <= 1'b0; end
                    K_COL_IN: begin
                        if ((st == S_PROG && acnt == 3'd4) || st == S_PCOL) begin
                            st <= S_PCOL; acnt <= '0;
                        end else begin
                            st <= S_PROG; acnt <= '0; cb <= 1'b1; data_seen <= 1'b0;
                        end
                    end
                    K_PG_GO: begin
                        st <= S_IDLE;
                        if (pg_go) begin
                            arr_start <= 1'b1; op_q <= OP_PROG; arr_row <= row; fail <= 1'b0;
                        end else if (pg_conf) fail <= 1'b1;
                    end
                    K_ER_SETUP: begin st <= S_ER_ADDR; acnt <= '0; end
                    K_ER_GO: begin
                        st <= S_IDLE;
                        if (er_go) begin
                            arr_start <= 1'b1; op_q <= OP_ERASE; arr_row <= row & ROW_MASK; fail <= 1'b0;
                        end else if (er_conf) fail <= 1'b1;
                    end
                    K_COL_OUT: if (osel == OUT_PAGE) begin st <= S_OCOL; acnt <= '0; end
                    K_COL_DONE: st <= S_IDLE;
                    K_STATUS: osel <= OUT_STAT;
                    K_IDENT: begin st <= S_ID_ADDR; osel <= OUT_ID; id_ok <= 1'b0; id_idx <= '0; end
                    default: ;
                endcase
            end else if (adr_ev && !busy) begin
                case (st)
                    S_RD_ADDR, S_PROG: if (acnt < 3'd4) begin
                        acnt <= acnt + 1'b1;
                        case (acnt)
                            3'd0:    col_lo <= cyc_byte;
                            3'd1:    col <= col_addr;
                            3'd2:    row.lo <= cyc_byte;
                            default: row.hi <= cyc_byte;
                        endcase
                    end
                    S_PCOL, S_OCOL: begin
                        if (acnt == 3'd0) begin
                            col_lo <= cyc_byte; acnt <= 3'd1;
                        end else if (acnt == 3'd1) begin
                            col <= col_addr;
                            if (st == S_PCOL) begin st <= S_PROG; acnt <= 3'd4; end
                            else acnt <= 3'd2;
                        end
                    end
                    S_ER_ADDR: if (acnt < 3'd2) begin
                        acnt <= acnt + 1'b1;
                        if (acnt == 3'd0) row.lo <= cyc_byte;
                        else              row.hi <= cyc_byte;
                    end
                    S_ID_ADDR: begin id_ok <= (cyc_byte == 8'h00); st <= S_IDLE; end
                    default: ;
                endcase
            end else if (buf_we) begin
                col <= col_inc; data_seen <= 1'b1;
            end else if (rd_strobe && !busy && !cyc_valid) begin
                if (osel == OUT_PAGE) col <= col_inc;
                else if (osel == OUT_ID && id_idx < 3'd5) id_idx <= id_idx + 1'b1;
            end
        end
    end

    assign arr_op = op_q;

    nand_busy_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .busy(busy)
    );

    nand_page_buf #(.COLS(COLS), .AW(COL_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(col), .wdata(cyc_byte), .raddr(col), .rdata(page_byte)
    );

    nand_rd_mux u_mux (
        .sel(osel), .stat(status_byte(wp_n, busy, fail)), .id_ok(id_ok), .id_idx(id_idx),
        .page_byte(page_byte), .rd_byte(rd_byte)
    );
endmodule

// File: rtl/nand_cmd_ctrl_chk.sv
module nand_cmd_ctrl_chk #(
    parameter int PAGE_BITS = 6
) (
    input logic        clk,
    input logic        rst,
    input logic        cyc_valid,
    input logic [1:0]  cyc_kind,
    input logic [7:0]  cyc_byte,
    input logic        wp_n,
    input logic [7:0]  rd_byte,
    input logic        busy,
    input logic        arr_start,
    input logic [1:0]  arr_op,
    input logic [15:0] arr_row
);
    assert_request_busy_R1: assert property (@(posedge clk) disable iff (rst)
        arr_start |-> busy);

    assert_erase_row_R2: assert property (@(posedge clk) disable iff (rst)
        (arr_start && arr_op == 2'd3) |-> (arr_row[PAGE_BITS-1:0] == '0));

    assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 2'd1 && busy && cyc_byte != 8'hFF) |=> !arr_start);

    assert_abort_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 2'd1 && cyc_byte == 8'hFF) |=> (busy && !arr_start));

    assert_status_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_kind == 2'd1 && cyc_byte == 8'h70) |=>
        (rd_byte[7] == wp_n && rd_byte[6] == !busy && rd_byte[5:1] == '0));

    assert_wp_gate_R11: assert property (@(posedge clk) disable iff (rst)
        (arr_start && arr_op[1]) |-> $past(wp_n));
endmodule

bind nand_cmd_ctrl nand_cmd_ctrl_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
    .wp_n(wp_n), .rd_byte(rd_byte), .busy(busy), .arr_start(arr_start), .arr_op(arr_op),
    .arr_row(arr_row)
);

// File: tb/tb_nand_cmd_ctrl.sv
module tb_nand_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 2112;
    localparam int T_LOAD = 20, T_PROG = 40, T_ERASE = 60, T_RST = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_valid = 1'b0;
    logic [1:0] cyc_kind = 2'd0;
    logic [7:0] cyc_byte = 8'h00;
    logic wp_n = 1'b1;
    logic rd_strobe = 1'b0;
    logic [7:0] rd_byte;
    logic busy, arr_start;
    logic [1:0] arr_op;
    logic [15:0] arr_row;

    int n_chk = 0, n_fail = 0, n_starts = 0;
    logic [1:0] last_op = 2'd0;
    logic [15:0] last_row = 16'h0;
    logic [7:0] model [COLS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_cmd_ctrl #(.COLS(COLS), .PAGE_BITS(6), .T_LOAD(T_LOAD), .T_PROG(T_PROG),
                    .T_ERASE(T_ERASE), .T_RST(T_RST)) dut (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .wp_n(wp_n), .rd_strobe(rd_strobe), .rd_byte(rd_byte), .busy(busy),
        .arr_start(arr_start), .arr_op(arr_op), .arr_row(arr_row)
    );

    always @(posedge clk) begin
        #1;
        if (arr_start) begin
            n_starts = n_starts + 1;
            last_op = arr_op;
            last_row = arr_row;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [7:0] b);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_kind = k; cyc_byte = b;
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b); send(2'd1, b); endtask
    task automatic adr(input logic [7:0] b); send(2'd2, b); endtask
    task automatic dat(input logic [7:0] b); send(2'd0, b); endtask

    task automatic addr4(input int c, input logic [15:0] r);
        adr(c[7:0]); adr({4'b0, c[11:8]}); adr(r[7:0]); adr(r[15:8]);
    endtask

    task automatic strobe();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    function automatic logic [7:0] exp_status(input logic w, input logic b, input logic f);
        return {w, ~b, 5'b0, f};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, c, len, s0;
        logic [15:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset no request", n_starts, 0);

        // R9: page read straight after reset, no 00h
        addr4(0, 16'h0005); cmd(8'h30);
        chk("R9 read start", n_starts, 1);
        chk("R1 read op", last_op, 0);
        chk("R2 read row", last_row, 16'h0005);
        wait_ready(n); chk("R1 load time", n, T_LOAD);
        cmd(8'h70); chk("R7 ready status", rd_byte, exp_status(1, 0, 0));

        // random program then read back
        for (int it = 0; it < 4; it++) begin
            c = $urandom % 2100; len = 1 + ($urandom % 8); r = 16'($urandom);
            cmd(8'h80); addr4(c, r);
            for (int i = 0; i < len; i++) begin
                model[c + i] = 8'($urandom);
                dat(model[c + i]);
            end
            s0 = n_starts; cmd(8'h10);
            chk("R1 program start", n_starts, s0 + 1);
            chk("R1 program op", last_op, 2);
            chk("R2 program row", last_row, r);
            wait_ready(n); chk("R1 program time", n, T_PROG);
            cmd(8'h00); addr4(c, r); cmd(8'h30); wait_ready(n);
            for (int i = 0; i < len; i++) begin
                chk("R3 R4 data readback", rd_byte, model[c + i]);
                strobe();
            end
        end

        // R3: column change during input, saturating writes
        cmd(8'h80); addr4(10, 16'h0100);
        dat(8'hA1); dat(8'hB2); model[10] = 8'hA1; model[11] = 8'hB2;
        cmd(8'h85); adr(8'h3E); adr(8'h08);
        dat(8'h5C); dat(8'h6D); dat(8'h7E);
        model[2110] = 8'h5C; model[2111] = 8'h7E;
        cmd(8'h10); wait_ready(n);
        cmd(8'h00); addr4(10, 16'h0100); cmd(8'h30); wait_ready(n);
        chk("R3 first byte", rd_byte, 8'hA1);
        strobe(); chk("R3 second byte", rd_byte, 8'hB2);
        // R4: random output column
        cmd(8'h05); adr(8'h3E); adr(8'h08); cmd(8'hE0);
        chk("R4 column moved", rd_byte, 8'h5C);
        strobe(); chk("R3 saturated write", rd_byte, 8'h7E);
        strobe(); chk("R4 column saturates", rd_byte, 8'h7E);
        // R2: oversized column clamps
        cmd(8'h00); adr(8'h00); adr(8'h00); adr(8'hFF); adr(8'h0F);
        chk("R2 address sets column", rd_byte, model[0]);
        cmd(8'h05); adr(8'hFF); adr(8'h0F); cmd(8'hE0);
        chk("R2 column clamp", rd_byte, 8'h7E);

        // R7: sticky status
        cmd(8'h70); chk("R7 status", rd_byte, 8'hC0);
        strobe(); chk("R7 status sticky", rd_byte, 8'hC0);
        cmd(8'h05); adr(8'h0A); adr(8'h00); cmd(8'hE0);
        chk("R7 05h keeps status", rd_byte, 8'hC0);
        cmd(8'h00); adr(8'h0A); adr(8'h00);
        chk("R7 00h returns page", rd_byte, 8'hA1);

        // R8: identification
        cmd(8'h90); adr(8'h00);
        chk("R8 id 0", rd_byte, 8'hC8); strobe();
        chk("R8 id 1", rd_byte, 8'hD1); strobe();
        chk("R8 id 2", rd_byte, 8'h80); strobe();
        chk("R8 id 3", rd_byte, 8'h95); strobe();
        chk("R8 id 4", rd_byte, 8'h42); strobe();
        chk("R8 id end", rd_byte, 8'h00);
        cmd(8'h90); adr(8'h01);
        chk("R8 bad id address", rd_byte, 8'h00);

        // R1 R10: copy-back read and program without data
        cmd(8'h00); addr4(0, 16'h0042); s0 = n_starts; cmd(8'h35);
        chk("R1 copy read start", n_starts, s0 + 1);
        chk("R1 copy read op", last_op, 1);
        wait_ready(n); chk("R1 copy read time", n, T_LOAD);
        cmd(8'h85); addr4(0, 16'h0077); cmd(8'h10);
        chk("R10 copy program without data", n_starts, s0 + 2);
        chk("R1 copy program op", last_op, 2);
        chk("R2 copy program row", last_row, 16'h0077);
        wait_ready(n);
        s0 = n_starts;
        cmd(8'h80); addr4(0, 16'h0033); cmd(8'h10);
        chk("R10 no data no start", n_starts, s0);
        chk("R10 busy stays low", busy, 0);

        // R6: reset aborts a program
        cmd(8'h80); addr4(5, 16'h0009); dat(8'h11); model[5] = 8'h11;
        cmd(8'h10);
        cmd(8'h70); chk("R7 busy status", rd_byte, 8'h80);
        s0 = n_starts;
        cmd(8'hFF); wait_ready(n);
        chk("R6 reset time", n, T_RST);
        chk("R6 no new request", n_starts, s0);
        cmd(8'h70); chk("R6 status after reset", rd_byte, 8'hC0);
        addr4(0, 16'h0021); cmd(8'h30);
        chk("R9 read after reset", n_starts, s0 + 1);
        chk("R9 read op after reset", last_op, 0);
        wait_ready(n);

        // R11: write protect
        wp_n = 1'b0; s0 = n_starts;
        cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
        chk("R11 protected no start", n_starts, s0);
        chk("R11 protected no busy", busy, 0);
        cmd(8'h70); chk("R11 fail status", rd_byte, 8'h41);
        wp_n = 1'b1;
        @(negedge clk); chk("R7 wp bit live", rd_byte, 8'hC1);
        cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0);
        chk("R1 erase start", n_starts, s0 + 1);
        chk("R1 erase op", last_op, 3);
        chk("R2 erase row masked", last_row, 16'h1200);

        // R5: commands during busy are dropped
        cmd(8'h60); cmd(8'h90);
        wait_ready(n); chk("R1 erase time", n + 4, T_ERASE);
        chk("R11 fail cleared", rd_byte, 8'hC0);
        chk("R5 90h ignored while busy", rd_byte, 8'hC0);
        s0 = n_starts;
        adr(8'h40); adr(8'h00); cmd(8'hD0);
        chk("R5 60h ignored while busy", n_starts, s0);
        chk("R5 idle after dropped setup", busy, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule